// File: doc/BRIEF.md
# Memory Segment Playback Address Controller

This block generates the read address for a 1024-word, 32-bit waveform memory that feeds a direct digital synthesizer. Four profiles each describe a segment of the memory: a first address, a last address, a 16-bit step interval counted in sync-clock ticks, and a 3-bit playback mode code. The two profile select inputs pick the active profile.

Depending on the mode, the address holds at the segment's first word, ramps once, ramps under external direction control, sweeps back and forth on its own, or wraps around the segment. A routing flag decides where the memory word goes. It can replace the frequency tuning word. It can instead supply its upper 14 bits as the phase offset, while the programmed tuning word keeps driving the phase accumulator. While memory playback is disabled, the programmed tuning and phase values pass through and the address rests at zero.

Top module: `seg_playback_ctrl`

## Requirements
- R1: While `mem_en` is low, `mem_addr` is 0 from the next clock onward, `ftw_out` equals `reg_ftw` and `pow_out` equals `reg_pow`.
- R2: A rise of `mem_en`, a high `update`, or a change of `prof_sel` (except in the bidirectional mode of R6) loads the selected profile's first address into `mem_addr` on the next clock and restarts its interval count.
- R3: The address moves only on cycles with `tick` high. A move happens on the N-th tick after a restart or after the previous move, where N is the profile's interval and an interval of 0 behaves as 1.
- R4: Mode code 000, and the unused codes 101 to 111, hold `mem_addr` at the profile's first address.
- R5: Mode code 001 steps up by one per interval from the first address until it reaches the last address, then holds there.
- R6: When profile 0 carries mode code 010, profile 0's segment is used whatever `prof_sel` says. `prof_sel[0]`=1 steps up toward the last address and `prof_sel[0]`=0 steps down toward the first address, holding at either bound. Changes of `prof_sel` do not reload the address.
- R7: Mode code 011 steps up to the last address, then down to the first address, and keeps reversing at each bound.
- R8: Mode code 100 steps up to the last address and on the next move returns to the first address.
- R9: A last address below the first address makes a one-word segment that holds at the first address.
- R10: With `mem_en` high and `dest_phase` low, `ftw_out` is `mem_rdata` and `pow_out` is `reg_pow`. With `dest_phase` high, `ftw_out` is `reg_ftw` and `pow_out` is `mem_rdata[31:18]`.

Profile k occupies bits [10k+9:10k] of `seg_first`, [10k+9:10k] of `seg_last`, [16k+15:16k] of `seg_rate` and [3k+2:3k] of `seg_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sync-clock tick enable for the interval count |
| mem_en | input | 1 | Memory playback enable |
| dest_phase | input | 1 | Route the memory word to the phase offset (1) or the tuning word (0) |
| update | input | 1 | Update strobe, restarts playback |
| prof_sel | input | 2 | Profile select; bit 0 is the direction in bidirectional mode |
| seg_first | input | 40 | First address of each profile |
| seg_last | input | 40 | Last address of each profile |
| seg_rate | input | 64 | Step interval of each profile in ticks |
| seg_mode | input | 12 | Mode code of each profile |
| mem_rdata | input | 32 | Word read from the memory |
| reg_ftw | input | 32 | Programmed frequency tuning word |
| reg_pow | input | 14 | Programmed phase offset word |
| mem_addr | output | 10 | Memory read address |
| ftw_out | output | 32 | Tuning word sent to the phase accumulator |
| pow_out | output | 14 | Phase offset sent to the phase adder |

## Verification
The hardest situation to reach is the bidirectional mode. There a change on the profile inputs must steer the ramp without reloading it, while in every other mode the same change reloads the address. The stimulus ramps profile 0 up to its bound, then flips `prof_sel[0]` and also raises `prof_sel[1]` in mid-ramp, so that a wrong reload would show at once as a jump back to the first address. Both reversal points of the continuous sweep, the wrap of the recirculating mode, and a stall with `tick` held low are reached through fixed sequences of profile switches and update strobes.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [2:0] {
    MODE_DIRECT = 3'b000,
    MODE_RAMP   = 3'b001,
    MODE_BIDIR  = 3'b010,
    MODE_CBIDIR = 3'b011,
    MODE_RECIRC = 3'b100
  } mode_e;
endpackage

// File: rtl/rsp_profile_sel.sv
module rsp_profile_sel #(
  parameter int NPROF = 4,
  parameter int AW    = 10,
  parameter int RW    = 16,
  parameter int PW    = 2
) (
  input  logic [NPROF*AW-1:0] first_flat,
  input  logic [NPROF*AW-1:0] last_flat,
  input  logic [NPROF*RW-1:0] rate_flat,
  input  logic [NPROF*3-1:0]  mode_flat,
  input  logic [PW-1:0]       idx,
  output logic [AW-1:0]       first_addr,
  output logic [AW-1:0]       last_addr,
  output logic [RW-1:0]       rate,
  output rsp_pkg::mode_e      mode
);
  logic [AW-1:0] first_a [NPROF];
  logic [AW-1:0] last_a  [NPROF];
  logic [RW-1:0] rate_a  [NPROF];
  logic [2:0]    mode_a  [NPROF];

  for (genvar k = 0; k < NPROF; k++) begin : g_unpack
    assign first_a[k] = first_flat[k*AW +: AW];
    assign last_a[k]  = last_flat[k*AW +: AW];
    assign rate_a[k]  = rate_flat[k*RW +: RW];
    assign mode_a[k]  = mode_flat[k*3 +: 3];
  end

  assign first_addr = first_a[idx];
  assign last_addr  = last_a[idx];
  assign rate       = rate_a[idx];
  assign mode       = rsp_pkg::mode_e'(mode_a[idx]);
endmodule

// File: rtl/rsp_interval_timer.sv
module rsp_interval_timer #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          tick,
  input  logic [RW-1:0] rate,
  output logic          step
);
  logic [RW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    step   = 1'b0;
    if (load) begin
      cnt_d  = rate;
      cnt_en = 1'b1;
    end else if (tick) begin
      cnt_en = 1'b1;
      if (cnt_q <= RW'(1)) begin
        step  = 1'b1;
        cnt_d = rate;
      end else begin
        cnt_d = cnt_q - RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rsp_addr_seq.sv
module rsp_addr_seq #(
  parameter int AW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           restart,
  input  logic           step,
  input  rsp_pkg::mode_e mode,
  input  logic [AW-1:0]  first_addr,
  input  logic [AW-1:0]  last_addr,
  input  logic           dir_up,
  output logic [AW-1:0]  addr
);
  import rsp_pkg::*;

  logic [AW-1:0] addr_q, addr_d;
  logic          up_q, up_d;
  logic [AW-1:0] bound;
  logic          at_top, at_bot, wide;

  // A reversed segment collapses onto its first word.
  assign bound  = (last_addr < first_addr) ? first_addr : last_addr;
  assign at_top = (addr_q >= bound);
  assign at_bot = (addr_q <= first_addr);
  assign wide   = (bound != first_addr);

  always_comb begin
    addr_d = addr_q;
    up_d   = up_q;
    if (!run) begin
      addr_d = '0;
      up_d   = 1'b1;
    end else if (restart) begin
      addr_d = first_addr;
      up_d   = 1'b1;
    end else begin
      unique case (mode)
        MODE_RAMP: begin
          if (step && !at_top) addr_d = addr_q + AW'(1);
        end
        MODE_BIDIR: begin
          if (step) begin
            if (dir_up && !at_top)       addr_d = addr_q + AW'(1);
            else if (!dir_up && !at_bot) addr_d = addr_q - AW'(1);
          end
        end
        MODE_CBIDIR: begin
          if (step) begin
            if (up_q) begin
              if (!at_top) addr_d = addr_q + AW'(1);
              else if (wide) begin
                addr_d = addr_q - AW'(1);
                up_d   = 1'b0;
              end
            end else begin
              if (!at_bot) addr_d = addr_q - AW'(1);
              else if (wide) begin
                addr_d = addr_q + AW'(1);
                up_d   = 1'b1;
              end
            end
          end
        end
        MODE_RECIRC: begin
          if (step) addr_d = at_top ? first_addr : addr_q + AW'(1);
        end
        default: addr_d = first_addr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      up_q   <= 1'b1;
    end else begin
      addr_q <= addr_d;
      up_q   <= up_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/seg_playback_ctrl.sv
module seg_playback_ctrl #(
  parameter int NPROF = 4,
  parameter int AW    = 10,
  parameter int RW    = 16,
  parameter int DW    = 32,
  parameter int PHW   = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   mem_en,
  input  logic                   dest_phase,
  input  logic                   update,
  input  logic [$clog2(NPROF)-1:0] prof_sel,
  input  logic [NPROF*AW-1:0]    seg_first,
  input  logic [NPROF*AW-1:0]    seg_last,
  input  logic [NPROF*RW-1:0]    seg_rate,
  input  logic [NPROF*3-1:0]     seg_mode,
  input  logic [DW-1:0]          mem_rdata,
  input  logic [DW-1:0]          reg_ftw,
  input  logic [PHW-1:0]         reg_pow,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          ftw_out,
  output logic [PHW-1:0]         pow_out
);
  import rsp_pkg::*;
  localparam int PW = $clog2(NPROF);

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [PW-1:0] prof_q;
  logic          en_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      prof_q <= '0;
      en_q   <= 1'b0;
    end else begin
      prof_q <= prof_sel;
      en_q   <= mem_en;
    end
  end

  logic          bidir_sel;
  logic [PW-1:0] eff_idx;
  logic          restart;
  logic [AW-1:0] first_addr, last_addr;
  logic [RW-1:0] rate;
  mode_e         mode;
  logic          step;

  assign bidir_sel = (seg_mode[2:0] == MODE_BIDIR);
  assign eff_idx   = bidir_sel ? '0 : prof_sel;
  assign restart   = mem_en & (update | ~en_q | (~bidir_sel & (prof_sel != prof_q)));

  rsp_profile_sel #(.NPROF(NPROF), .AW(AW), .RW(RW), .PW(PW)) u_psel (
    .first_flat (seg_first),
    .last_flat  (seg_last),
    .rate_flat  (seg_rate),
    .mode_flat  (seg_mode),
    .idx        (eff_idx),
    .first_addr (first_addr),
    .last_addr  (last_addr),
    .rate       (rate),
    .mode       (mode)
  );

  rsp_interval_timer #(.RW(RW)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (restart),
    .tick  (tick),
    .rate  (rate),
    .step  (step)
  );

  rsp_addr_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (mem_en),
    .restart    (restart),
    .step       (step),
    .mode       (mode),
    .first_addr (first_addr),
    .last_addr  (last_addr),
    .dir_up     (prof_sel[0]),
    .addr       (mem_addr)
  );

  // Routing of the memory word to frequency or phase path.
  assign ftw_out = (mem_en && !dest_phase) ? mem_rdata : reg_ftw;
  assign pow_out = (mem_en && dest_phase) ? mem_rdata[DW-1 -: PHW] : reg_pow;
endmodule

// File: rtl/rsp_checks.sv
module rsp_checks #(
  parameter int NPROF = 4,
  parameter int AW    = 10,
  parameter int RW    = 16,
  parameter int DW    = 32,
  parameter int PHW   = 14
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic                     mem_en,
  input logic                     dest_phase,
  input logic                     update,
  input logic [$clog2(NPROF)-1:0] prof_sel,
  input logic [NPROF*AW-1:0]      seg_first,
  input logic [NPROF*3-1:0]       seg_mode,
  input logic [DW-1:0]            mem_rdata,
  input logic [DW-1:0]            reg_ftw,
  input logic [AW-1:0]            mem_addr,
  input logic [DW-1:0]            ftw_out,
  input logic [PHW-1:0]           pow_out
);
  logic [2:0] sel_mode;
  assign sel_mode = seg_mode[prof_sel*3 +: 3];

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |=> mem_addr == '0);

  assert_update_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && update && prof_sel == '0) |=> mem_addr == $past(seg_first[AW-1:0]));

  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en) && !tick && !update && $stable(prof_sel)
     && $stable(seg_mode) && $stable(seg_first)) |=> $stable(mem_addr));

  assert_direct_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en) && !update && $stable(prof_sel) && $stable(seg_mode)
     && $stable(seg_first) && sel_mode == 3'b000 && seg_mode[2:0] != 3'b010)
    |=> $stable(mem_addr));

  assert_phase_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && dest_phase) |-> (pow_out == mem_rdata[DW-1 -: PHW] && ftw_out == reg_ftw));
endmodule

bind seg_playback_ctrl rsp_checks #(
  .NPROF(NPROF), .AW(AW), .RW(RW), .DW(DW), .PHW(PHW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .mem_en     (mem_en),
  .dest_phase (dest_phase),
  .update     (update),
  .prof_sel   (prof_sel),
  .seg_first  (seg_first),
  .seg_mode   (seg_mode),
  .mem_rdata  (mem_rdata),
  .reg_ftw    (reg_ftw),
  .mem_addr   (mem_addr),
  .ftw_out    (ftw_out),
  .pow_out    (pow_out)
);

// File: tb/seg_playback_ctrl_test.sv
module seg_playback_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, mem_en, dest_phase, update;
  logic [1:0]  prof_sel;
  logic [39:0] seg_first, seg_last;
  logic [63:0] seg_rate;
  logic [11:0] seg_mode;
  logic [31:0] mem_rdata, reg_ftw;
  logic [13:0] reg_pow;
  logic [9:0]  mem_addr;
  logic [31:0] ftw_out;
  logic [13:0] pow_out;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  seg_playback_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mem_en(mem_en), .dest_phase(dest_phase),
    .update(update), .prof_sel(prof_sel), .seg_first(seg_first), .seg_last(seg_last),
    .seg_rate(seg_rate), .seg_mode(seg_mode), .mem_rdata(mem_rdata), .reg_ftw(reg_ftw),
    .reg_pow(reg_pow), .mem_addr(mem_addr), .ftw_out(ftw_out), .pow_out(pow_out)
  );

  typedef struct {
    logic [9:0]  addr;
    logic [31:0] ftw;
    logic [13:0] pow;
    string       tag;
  } item_t;

  item_t sb[$];

  // Driver: record what the requirements predict after the coming edge.
  task automatic cyc(input logic [9:0] ea, input string tag);
    item_t it;
    it.addr = ea;
    it.ftw  = (mem_en && !dest_phase) ? mem_rdata : reg_ftw;
    it.pow  = (mem_en && dest_phase) ? mem_rdata[31:18] : reg_pow;
    it.tag  = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compare just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (mem_addr !== it.addr || ftw_out !== it.ftw || pow_out !== it.pow) begin
          errors++;
          $display("FAIL %s: addr=%0d ftw=%h pow=%h expected addr=%0d ftw=%h pow=%h",
                   it.tag, mem_addr, ftw_out, pow_out, it.addr, it.ftw, it.pow);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; mem_en = 1'b0; dest_phase = 1'b0; update = 1'b0;
    prof_sel  = 2'd0;
    seg_first = {10'd300, 10'd200, 10'd100, 10'd10};
    seg_last  = {10'd302, 10'd199, 10'd102, 10'd13};
    seg_rate  = {16'd1, 16'd1, 16'd2, 16'd1};
    seg_mode  = 12'h000;
    mem_rdata = 32'hA5C3_1234;
    reg_ftw   = 32'h1357_9BDF;
    reg_pow   = 14'h0ABC;

    repeat (3) @(negedge clk);
    checks++;
    if (mem_addr !== 10'd0 || ftw_out !== reg_ftw || pow_out !== reg_pow) begin
      errors++;
      $display("FAIL R1 reset: addr=%0d ftw=%h pow=%h expected addr=0 ftw=%h pow=%h",
               mem_addr, ftw_out, pow_out, reg_ftw, reg_pow);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 idle with either routing
    cyc(10'd0, "R1 idle");
    dest_phase = 1'b1;
    cyc(10'd0, "R1 idle phase flag");
    dest_phase = 1'b0;

    // R4 direct switch across profiles, R2 reloads
    mem_en = 1'b1;
    cyc(10'd10, "R2 enable");
    cyc(10'd10, "R4 direct hold");
    prof_sel = 2'd1;
    cyc(10'd100, "R2 profile change");
    cyc(10'd100, "R4 direct hold p1");
    seg_mode = {3'b101, 3'b000, 3'b000, 3'b000};
    prof_sel = 2'd3;
    cyc(10'd300, "R2 profile change p3");
    cyc(10'd300, "R4 unused code holds");
    dest_phase = 1'b1;
    cyc(10'd300, "R10 phase route");
    dest_phase = 1'b0;
    cyc(10'd300, "R10 freq route");

    // R5 single ramp
    seg_mode = {3'b100, 3'b001, 3'b001, 3'b001};
    prof_sel = 2'd0;
    cyc(10'd10, "R2 to p0");
    cyc(10'd11, "R5 ramp");
    cyc(10'd12, "R5 ramp");
    cyc(10'd13, "R5 ramp top");
    cyc(10'd13, "R5 hold at last");
    cyc(10'd13, "R5 hold at last");

    // R3 tick gating
    update = 1'b1;
    cyc(10'd10, "R2 update strobe");
    update = 1'b0;
    tick = 1'b0;
    cyc(10'd10, "R3 no tick");
    cyc(10'd10, "R3 no tick");
    tick = 1'b1;
    cyc(10'd11, "R3 tick resumes");

    // R3 interval of 2
    prof_sel = 2'd1;
    cyc(10'd100, "R2 to p1");
    cyc(10'd100, "R3 interval 2 wait");
    cyc(10'd101, "R3 interval 2 step");
    cyc(10'd101, "R3 interval 2 wait");
    cyc(10'd102, "R3 interval 2 step");
    cyc(10'd102, "R5 hold p1");

    // R9 reversed segment
    prof_sel = 2'd2;
    cyc(10'd200, "R2 to p2");
    cyc(10'd200, "R9 one-word segment");
    cyc(10'd200, "R9 one-word segment");

    // R8 recirculate
    prof_sel = 2'd3;
    cyc(10'd300, "R2 to p3");
    cyc(10'd301, "R8 ramp");
    cyc(10'd302, "R8 top");
    cyc(10'd300, "R8 wrap to first");
    cyc(10'd301, "R8 after wrap");

    // R7 continuous bidirectional
    seg_mode = {3'b100, 3'b001, 3'b001, 3'b011};
    prof_sel = 2'd0;
    cyc(10'd10, "R2 to p0 sweep");
    cyc(10'd11, "R7 up");
    cyc(10'd12, "R7 up");
    cyc(10'd13, "R7 top");
    cyc(10'd12, "R7 reverse at top");
    cyc(10'd11, "R7 down");
    cyc(10'd10, "R7 bottom");
    cyc(10'd11, "R7 reverse at bottom");

    // R6 bidirectional under prof_sel[0]
    seg_mode = {3'b100, 3'b001, 3'b001, 3'b010};
    prof_sel = 2'd1;
    update = 1'b1;
    cyc(10'd10, "R2 update into bidir");
    update = 1'b0;
    cyc(10'd11, "R6 up");
    cyc(10'd12, "R6 up");
    cyc(10'd13, "R6 up top");
    cyc(10'd13, "R6 clamp top");
    prof_sel = 2'd0;
    cyc(10'd12, "R6 down no reload");
    prof_sel = 2'd2;
    cyc(10'd11, "R6 profile 0 only");
    cyc(10'd10, "R6 down to first");
    cyc(10'd10, "R6 clamp bottom");

    // R1 disable, R2 re-enable
    mem_en = 1'b0;
    cyc(10'd0, "R1 disable");
    cyc(10'd0, "R1 disable hold");
    mem_en = 1'b1;
    cyc(10'd10, "R2 re-enable");

    // R10 routing with direct switch
    seg_mode = 12'h000;
    prof_sel = 2'd1;
    mem_rdata = 32'h0F0F_8001;
    cyc(10'd100, "R10 freq route p1");
    dest_phase = 1'b1;
    cyc(10'd100, "R10 phase route p1");
    mem_en = 1'b0;
    cyc(10'd0, "R1 idle routing");

    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule